// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is the management-bus master for Ethernet PHYs. It generates the MDC clock, serializes one management frame onto MDIO and, for reads, collects sixteen data bits returned by the PHY. Clause 22 and Clause 45 accesses use the same frame and are told apart by the start code that software places in the command word.

Software sees a single 32-bit command/status register on a plain write-strobe bus, and the read side is always presented on the register output. A write with the go bit set launches exactly one frame built from the packed fields. The go bit then reads as busy until the frame has gone out. Software polls the busy bit, and after a read frame it takes the returned value from the low sixteen bits. A Clause 45 register access takes two commands from software: an address frame, then a data frame. MDC runs only while a frame is in flight. Its half period, counted in system clocks, is a parameter.

Top module: `mdio_master`

## Requirements
- R1: After reset the register reads 0x4000_0000: busy (bit 31) clear, ready (bit 30) set, all fields zero. MDC is low and MDIO is released (`mdio_oe` low).
- R2: A write with bit 31 set while idle stores bits 29:0 and starts a frame. Bit 31 reads 1 and bit 30 reads 0 until the frame ends, and then they read 0 and 1. A write with bit 31 clear stores the fields and starts no frame.
- R3: A frame is 64 MDC cycles sent MSB first: 32 ones, then bits 17:16 (start code), bits 19:18 (opcode), bits 24:20 (PHY address), bits 29:25 (register or device address), two turnaround bits, and sixteen data bits.
- R4: A frame is a read when bits 17:16 are 01 and bits 19:18 are 10, or when bits 17:16 are not 01 and bit 19 is 1. Every other frame is a write-type frame: it drives turnaround 1,0 and then bits 15:0, and bits 15:0 keep their value after the frame.
- R5: During a read frame the master drives MDIO through the first 46 bit times and releases it for the turnaround and the data phase.
- R6: A read clears bits 15:0 when it starts. The bits sampled on the last sixteen MDC rising edges are stored in bits 15:0, first sample in bit 15. A PHY that does not answer therefore reads 0xFFFF.
- R7: MDIO and its enable change only on MDC falling edges while a frame runs. MDC stays low whenever the block is not busy.
- R8: The MDC period is 2*DIV_HALF system clocks.
- R9: A register write that arrives while busy is set has no effect on the fields and does not start another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write value |
| reg_rd_data | output | 32 | Current register value (busy, ready, fields) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_i | input | 1 | MDIO value seen on the pad |

## Verification
The embedded assertions check four things on every cycle. Busy stays set for the whole frame. Writes made while busy leave the fields unchanged. MDIO and its enable move only on MDC falling edges. MDC and the MDIO enable are both low whenever the block is idle. Only the bench's scenarios can show the other behaviours. Those are the exact bit order of each frame type, which opcode and start code combinations release the line, the value returned by a present PHY and by an absent one, and the measured MDC period.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int unsigned PRE_LEN   = 32;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned FRAME_LEN = PRE_LEN + 2 + 2 + 2*ADDR_W + 2 + DATA_W;
  localparam int unsigned TA_POS    = FRAME_LEN - DATA_W - 2;
  localparam int unsigned DATA_POS  = FRAME_LEN - DATA_W;

  typedef struct packed {
    logic [ADDR_W-1:0] regad;
    logic [ADDR_W-1:0] phy;
    logic [1:0]        op;
    logic [1:0]        st;
    logic [DATA_W-1:0] data;
  } cmd_t;

  function automatic logic cmd_is_read(cmd_t c);
    if (c.st == 2'b01) return (c.op == 2'b10);
    return c.op[1];
  endfunction

  function automatic logic [FRAME_LEN-1:0] build_frame(cmd_t c);
    logic rd;
    rd = cmd_is_read(c);
    return {{PRE_LEN{1'b1}}, c.st, c.op, c.phy, c.regad,
            rd ? 2'b11 : 2'b10,
            rd ? {DATA_W{1'b1}} : c.data};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned DIV_HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned CW = $clog2(DIV_HALF + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          term;

  assign term = (cnt_q == CW'(DIV_HALF - 1));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!en) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = en && term && !mdc_q;
  assign fall_tick = en && term &&  mdc_q;

  // R8
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !term) |=> $stable(mdc_q));

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cmd_t              cmd,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] rx_data
);
  localparam int unsigned PW = $clog2(FRAME_LEN);

  logic                 active_q, active_d;
  logic                 rd_q, rd_d;
  logic [PW-1:0]        pos_q, pos_d;
  logic [FRAME_LEN-1:0] tx_q, tx_d;
  logic [DATA_W-1:0]    rx_q, rx_d;
  logic                 last_bit;

  assign last_bit = (pos_q == PW'(FRAME_LEN - 1));
  assign done     = active_q && fall_tick && last_bit;

  always_comb begin
    active_d = active_q;
    rd_d     = rd_q;
    pos_d    = pos_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    if (start && !active_q) begin
      active_d = 1'b1;
      rd_d     = cmd_is_read(cmd);
      pos_d    = '0;
      tx_d     = build_frame(cmd);
      rx_d     = '0;
    end else if (active_q) begin
      if (rise_tick && rd_q && (pos_q >= PW'(DATA_POS)))
        rx_d = {rx_q[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        pos_d = pos_q + 1'b1;
        tx_d  = {tx_q[FRAME_LEN-2:0], 1'b1};
        if (last_bit) active_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      pos_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      active_q <= active_d;
      rd_q     <= rd_d;
      pos_q    <= pos_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
    end
  end

  assign mdio_o  = tx_q[FRAME_LEN-1];
  assign mdio_oe = active_q && !(rd_q && (pos_q >= PW'(TA_POS)));
  assign active  = active_q;
  assign rx_data = rx_q;

  // R7
  pin_change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !fall_tick) |=> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

// File: rtl/mdio_cmdreg.sv
module mdio_cmdreg
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              start,
  output cmd_t              new_cmd,
  output logic [31:0]       rd_data
);
  cmd_t cmd_q, cmd_d;
  logic busy_q, busy_d;
  logic unused_ready_bit;

  assign unused_ready_bit = wr_data[30];
  assign new_cmd = cmd_t'(wr_data[29:0]);
  assign start   = wr_en && !busy_q && wr_data[31];

  always_comb begin
    cmd_d  = cmd_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (done) begin
        busy_d = 1'b0;
        if (cmd_is_read(cmd_q)) cmd_d.data = rx_data;
      end
    end else if (wr_en) begin
      cmd_d  = new_cmd;
      busy_d = wr_data[31];
      if (wr_data[31] && cmd_is_read(new_cmd)) cmd_d.data = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      busy_q <= busy_d;
    end
  end

  assign busy    = busy_q;
  assign rd_data = {busy_q, ~busy_q, cmd_q};

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> busy_q);

  // R9
  wr_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done && wr_en) |=> $stable(cmd_q));

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int unsigned DIV_HALF = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wr_data,
  output logic [31:0] reg_rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  import mdio_pkg::*;

  logic              busy, start, done, active;
  logic              rise_tick, fall_tick;
  cmd_t              new_cmd;
  logic [DATA_W-1:0] rx_data;

  mdio_cmdreg u_cmdreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .done    (done),
    .rx_data (rx_data),
    .busy    (busy),
    .start   (start),
    .new_cmd (new_cmd),
    .rd_data (reg_rd_data)
  );

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd       (new_cmd),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .active    (active),
    .done      (done),
    .rx_data   (rx_data)
  );

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R2
  busy_frame_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == active);

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int n_checks = 0;
  int n_fail   = 0;

  // PHY responder state
  logic        resp_en = 1'b0;
  logic [15:0] resp_data = '0;
  logic [5:0]  bitn = '0;
  logic [63:0] cap_o = '0;
  logic [63:0] cap_oe = '0;
  int          rises = 0;
  longint      last_rise = 0;
  longint      period = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.DIV_HALF(DIV_HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  assign mdio_i = (resp_en && bitn >= 6'd48) ? resp_data[4'(6'd63 - bitn)] : 1'b1;

  always @(posedge mdc) begin
    cap_o     <= {cap_o[62:0], mdio_o};
    cap_oe    <= {cap_oe[62:0], mdio_oe};
    bitn      <= bitn + 6'd1;
    rises     <= rises + 1;
    period    <= $time - last_rise;
    last_rise <= $time;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic is_rd(logic [1:0] st, logic [1:0] op);
    return (st == 2'b01) ? (op == 2'b10) : op[1];
  endfunction

  function automatic logic [31:0] mk_word(logic go, logic [4:0] rg, logic [4:0] phy,
                                          logic [1:0] op, logic [1:0] st, logic [15:0] d);
    return {go, 1'b0, rg, phy, op, st, d};
  endfunction

  task automatic write_reg(input logic [31:0] w);
    @(negedge clk);
    reg_wr_en   = 1'b1;
    reg_wr_data = w;
    @(negedge clk);
    reg_wr_en   = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (reg_rd_data[31] && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 5000) check("R2 busy timeout", 64'd1, 64'd0);
  endtask

  task automatic run_cmd(input logic [4:0] rg, input logic [4:0] phy, input logic [1:0] op,
                         input logic [1:0] st, input logic [15:0] d,
                         input logic present, input logic [15:0] rsp);
    logic        rd;
    logic [63:0] exp_frame, exp_oe;
    logic [15:0] exp_d;
    int          r0;
    rd = is_rd(st, op);
    resp_en   = present;
    resp_data = rsp;
    r0 = rises;
    write_reg(mk_word(1'b1, rg, phy, op, st, d));
    check("R2 busy/ready after go", 64'(reg_rd_data[31:30]), 64'(2'b10));
    if (rd) check("R6 data cleared at read start", 64'(reg_rd_data[15:0]), 64'd0);
    wait_idle();
    exp_frame = {32'hFFFF_FFFF, st, op, phy, rg, 2'b10, d};
    exp_oe    = rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
    check("R5 mdio enable pattern", cap_oe, exp_oe);
    check(rd ? "R3 read frame header" : "R4 write frame bits",
          cap_o & exp_oe, exp_frame & exp_oe);
    check("R8 64 MDC cycles per frame", 64'(rises - r0), 64'd64);
    exp_d = rd ? (present ? rsp : 16'hFFFF) : d;
    check(rd ? "R6 read data" : "R4 write data kept",
          64'(reg_rd_data), 64'(mk_word(1'b0, rg, phy, op, st, exp_d) | 32'h4000_0000));
    check("R7 idle mdc/oe low", 64'({mdc, mdio_oe}), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 reset register", 64'(reg_rd_data), 64'h4000_0000);
    check("R1 reset pins", 64'({mdc, mdio_oe}), 64'd0);

    // R3 R4: clause 22 write
    run_cmd(5'h02, 5'h1F, 2'b01, 2'b01, 16'hA5C3, 1'b0, 16'h0);
    // R6: clause 22 read, PHY present
    run_cmd(5'h02, 5'h1F, 2'b10, 2'b01, 16'h1234, 1'b1, 16'h7500);
    // R6: read from absent PHY after a present one returns all ones
    run_cmd(5'h03, 5'h00, 2'b10, 2'b01, 16'h0000, 1'b0, 16'h7500);
    // R4: clause 45 address frame, then write, read, post-increment read
    run_cmd(5'h1E, 5'h05, 2'b00, 2'b00, 16'hC0DE, 1'b0, 16'h0);
    run_cmd(5'h1E, 5'h05, 2'b01, 2'b00, 16'h0F0F, 1'b0, 16'h0);
    run_cmd(5'h1E, 5'h05, 2'b11, 2'b00, 16'h0000, 1'b1, 16'h8001);
    run_cmd(5'h1E, 5'h05, 2'b10, 2'b00, 16'h0000, 1'b1, 16'hFFFE);
    // R4: clause 22 start with opcode 11 is a write-type frame
    run_cmd(5'h11, 5'h0A, 2'b11, 2'b01, 16'h5A5A, 1'b1, 16'h0000);

    // R8: measured MDC period
    check("R8 MDC period", 64'(period), 64'(2 * DIV_HALF * CLK_PERIOD));

    // R2: write with go clear stores fields, starts nothing
    begin
      int r0;
      r0 = rises;
      write_reg(mk_word(1'b0, 5'h07, 5'h09, 2'b10, 2'b01, 16'hBEEF));
      repeat (4 * DIV_HALF) @(negedge clk);
      check("R2 no-go write stores fields", 64'(reg_rd_data),
            64'(mk_word(1'b0, 5'h07, 5'h09, 2'b10, 2'b01, 16'hBEEF) | 32'h4000_0000));
      check("R2 no-go write starts no frame", 64'(rises - r0), 64'd0);
    end

    // R9: write while busy is ignored
    begin
      int r0;
      r0 = rises;
      resp_en = 1'b0;
      write_reg(mk_word(1'b1, 5'h04, 5'h03, 2'b01, 2'b01, 16'h1357));
      repeat (10) @(negedge clk);
      write_reg(mk_word(1'b1, 5'h1B, 5'h1C, 2'b10, 2'b01, 16'hFFFF));
      check("R9 fields unchanged during frame", 64'(reg_rd_data[29:0]),
            64'(mk_word(1'b0, 5'h04, 5'h03, 2'b01, 2'b01, 16'h1357) & 32'h3FFF_FFFF));
      wait_idle();
      repeat (8 * DIV_HALF) @(negedge clk);
      check("R9 only one frame", 64'(rises - r0), 64'd64);
      check("R9 frame of first command", cap_o,
            {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'h1357});
      check("R9 register after frame", 64'(reg_rd_data),
            64'(mk_word(1'b0, 5'h04, 5'h03, 2'b01, 2'b01, 16'h1357) | 32'h4000_0000));
    end

    // Random commands
    for (int i = 0; i < 30; i++) begin
      run_cmd(5'($urandom), 5'($urandom), 2'($urandom), 2'($urandom), 16'($urandom),
              1'($urandom), 16'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule